// File: doc/BRIEF.md
# Bright Marker Position Tracker

This block watches a camera pixel stream and locates a single bright marker in each frame. The camera delivers one byte per clock. Two consecutive bytes form a 16-bit RGB565 pixel. A line-valid signal frames each line and a frame-sync pulse closes each frame. Each pixel is tested against a programmable colour threshold. A pixel counts as marker only if each of its three colour fields is greater than or equal to the matching threshold field.

The block sums the column and row indices of all matching pixels. At frame end it divides each sum by the match count, giving the centroid of the marker. The centroid is latched into two read-only position registers. A small word-addressed register file holds the threshold, a control word and the two positions. A one-cycle interrupt marks each processed frame when interrupts are enabled. Writing the reset bit clears the datapath and raises a one-cycle request toward the camera configuration logic.

Top module: `marker_tracker`

## Requirements
- R1: While line-valid is high, bytes pair up into pixels. The first byte of each pair is bits 15:8 and the second is bits 7:0. Pairing restarts at every line.
- R2: The column index of a pixel is its position within the line, counted from 0. The row index starts at 0 after frame end and rises by one at each falling edge of line-valid.
- R3: A pixel matches when red (bits 4:0) >= threshold red, green (bits 10:5) >= threshold green, and blue (bits 15:11) >= threshold blue. An equal value matches.
- R4: On a rising edge of frame-sync while running, offset 2 becomes floor(sum of matching columns / match count) and offset 3 becomes floor(sum of matching rows / match count). Both are readable from the next cycle.
- R5: A frame with no matching pixel leaves offsets 2 and 3 unchanged and sets the no-marker flag (bit 3 of offset 1). A frame with a match clears that flag.
- R6: While the run bit (offset 1 bit 0) is 0, pixels are not accumulated, positions do not change and no interrupt is raised.
- R7: irq is high for exactly the one cycle after a frame end that occurs while running with interrupt enable (offset 1 bit 2) set. It stays low otherwise.
- R8: Writing offset 1 with bit 1 set clears the positions, the no-marker flag, the counters and the sums at that write's clock edge. cam_cfg_req pulses high for the following cycle. Bit 1 always reads back 0.
- R9: Reads are combinational. Offset 0 returns the 16-bit threshold. Offset 1 returns {no-marker, irq enable, 0, run} in bits 3:0. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_byte | input | 8 | Camera data byte |
| cam_line_valid | input | 1 | High during active pixels of a line |
| cam_frame_sync | input | 1 | Rising edge ends the current frame |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | One-cycle processed-frame interrupt |
| cam_cfg_req | output | 1 | One-cycle camera configuration request |

## Verification
The bench builds the block with its default coordinate width of 11 bits. It streams 12 by 6 pixel frames, which keeps every centroid hand-checkable. Small frames still reach single pixels, exact-threshold blocks, and decoys that miss by one step in a single field. They also reach corner pixels whose centroid needs floor rounding, and empty frames. The run, interrupt-enable and reset bits are toggled between frames. The interrupt and configuration-request outputs are compared against the model on every clock.

// File: rtl/marker_pkg.sv
package marker_pkg;

    // Word offsets of the register file
    localparam logic [1:0] OFS_COLOR = 2'd0;
    localparam logic [1:0] OFS_CTRL  = 2'd1;
    localparam logic [1:0] OFS_POSX  = 2'd2;
    localparam logic [1:0] OFS_POSY  = 2'd3;

    // Control word bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_RST  = 1;
    localparam int CTRL_IEN  = 2;
    localparam int CTRL_NOMK = 3;

    // Pixel layout: first packed field lands in the upper bits
    typedef struct packed {
        logic [4:0] blue;
        logic [5:0] green;
        logic [4:0] red;
    } rgb565_t;

    function automatic logic color_meets(rgb565_t pix, rgb565_t thr);
        return (pix.red >= thr.red) && (pix.green >= thr.green) && (pix.blue >= thr.blue);
    endfunction

endpackage

// File: rtl/mt_pixel_front.sv
module mt_pixel_front
    import marker_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [7:0]         cam_byte,
    input  logic               line_valid,
    input  logic               frame_sync,
    output logic               pix_valid,
    output rgb565_t            pix,
    output logic [COORD_W-1:0] col,
    output logic [COORD_W-1:0] row,
    output logic               frame_end
);

    logic       phase;
    logic [7:0] hi_byte;
    logic       lv_q;
    logic       fs_q;

    assign pix_valid = line_valid && phase;
    assign pix       = rgb565_t'({hi_byte, cam_byte});
    assign frame_end = frame_sync && !fs_q;

    // Edge detectors keep sampling even while idle to avoid false edges
    always_ff @(posedge clk) begin
        if (rst) begin
            lv_q <= 1'b0;
            fs_q <= 1'b0;
        end else begin
            lv_q <= line_valid;
            fs_q <= frame_sync;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase   <= 1'b0;
            hi_byte <= '0;
            col     <= '0;
            row     <= '0;
        end else begin
            if (!line_valid) begin
                phase <= 1'b0;
                col   <= '0;
            end else begin
                phase <= !phase;
                if (!phase) hi_byte <= cam_byte;
                else        col     <= col + 1'b1;
            end
            if (frame_end)
                row <= '0;
            else if (lv_q && !line_valid)
                row <= row + 1'b1;
        end
    end

    // R2: column count restarts whenever the line is inactive
    assert_col_resync_R2: assert property (@(posedge clk) disable iff (rst)
        !line_valid |=> (col == '0));

    // R1: a complete pixel never appears on two consecutive cycles
    assert_pixel_pairing_R1: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);

endmodule

// File: rtl/mt_accum.sv
module mt_accum
    import marker_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               go,
    input  logic               pix_valid,
    input  rgb565_t            pix,
    input  rgb565_t            thresh,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  logic               frame_end,
    output logic               frame_done,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               no_marker
);

    localparam int CNT_W = 2 * COORD_W;
    localparam int SUM_W = 3 * COORD_W;

    logic [SUM_W-1:0] sum_x;
    logic [SUM_W-1:0] sum_y;
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit        = go && pix_valid && color_meets(pix, thresh);
    assign frame_done = go && frame_end && !soft_rst;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            sum_x     <= '0;
            sum_y     <= '0;
            cnt       <= '0;
            pos_x     <= '0;
            pos_y     <= '0;
            no_marker <= 1'b0;
        end else if (!go) begin
            sum_x <= '0;
            sum_y <= '0;
            cnt   <= '0;
        end else if (frame_end) begin
            if (cnt != '0) begin
                pos_x     <= COORD_W'(sum_x / SUM_W'(cnt));
                pos_y     <= COORD_W'(sum_y / SUM_W'(cnt));
                no_marker <= 1'b0;
            end else begin
                no_marker <= 1'b1;
            end
            sum_x <= '0;
            sum_y <= '0;
            cnt   <= '0;
        end else if (hit) begin
            sum_x <= sum_x + SUM_W'(col);
            sum_y <= sum_y + SUM_W'(row);
            cnt   <= cnt + 1'b1;
        end
    end

    // R5: an empty frame keeps the old position and flags no marker
    assert_empty_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && cnt == '0) |=> (no_marker && pos_x == $past(pos_x) && pos_y == $past(pos_y)));

    // R4: a frame with matches clears the flag
    assert_found_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_done && cnt != '0) |=> !no_marker);

    // R6: nothing is accumulated while stopped
    assert_idle_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !go |=> (cnt == '0));

    // R8: soft reset wipes the reported state
    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (pos_x == '0 && pos_y == '0 && !no_marker && cnt == '0));

endmodule

// File: rtl/mt_regs.sv
module mt_regs
    import marker_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [15:0]        wdata,
    input  logic               frame_done,
    input  logic               no_marker,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    output logic [31:0]        rd_data,
    output rgb565_t            thresh,
    output logic               go,
    output logic               irq_en,
    output logic               soft_rst,
    output logic               irq,
    output logic               cfg_req
);

    assign soft_rst = wr_en && (addr == OFS_CTRL) && wdata[CTRL_RST];

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh  <= '0;
            go      <= 1'b0;
            irq_en  <= 1'b0;
            irq     <= 1'b0;
            cfg_req <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_COLOR) thresh <= rgb565_t'(wdata);
            if (wr_en && addr == OFS_CTRL) begin
                go     <= wdata[CTRL_RUN];
                irq_en <= wdata[CTRL_IEN];
            end
            irq     <= frame_done && irq_en;
            cfg_req <= soft_rst;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_COLOR: rd_data = {16'b0, thresh};
            OFS_CTRL:  rd_data = {28'b0, no_marker, irq_en, 1'b0, go};
            OFS_POSX:  rd_data = 32'(pos_x);
            default:   rd_data = 32'(pos_y);
        endcase
    end

    // R7: interrupt only follows an enabled state, and lasts one cycle
    assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: configuration request only follows a register write
    assert_cfg_from_write_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> $past(wr_en));

endmodule

// File: rtl/marker_tracker.sv
module marker_tracker
    import marker_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cam_byte,
    input  logic        cam_line_valid,
    input  logic        cam_frame_sync,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rd_data,
    output logic        irq,
    output logic        cam_cfg_req
);

    rgb565_t            thresh;
    rgb565_t            pix;
    logic               go;
    logic               irq_en;
    logic               soft_rst;
    logic               pix_valid;
    logic               frame_end;
    logic               frame_done;
    logic               no_marker;
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] pos_x;
    logic [COORD_W-1:0] pos_y;

    mt_pixel_front #(.COORD_W(COORD_W)) u_front (
        .clk        (clk),
        .rst        (rst),
        .clr        (soft_rst || !go),
        .cam_byte   (cam_byte),
        .line_valid (cam_line_valid),
        .frame_sync (cam_frame_sync),
        .pix_valid  (pix_valid),
        .pix        (pix),
        .col        (col),
        .row        (row),
        .frame_end  (frame_end)
    );

    mt_accum #(.COORD_W(COORD_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .go         (go),
        .pix_valid  (pix_valid),
        .pix        (pix),
        .thresh     (thresh),
        .col        (col),
        .row        (row),
        .frame_end  (frame_end),
        .frame_done (frame_done),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .no_marker  (no_marker)
    );

    mt_regs #(.COORD_W(COORD_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .frame_done (frame_done),
        .no_marker  (no_marker),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .rd_data    (reg_rd_data),
        .thresh     (thresh),
        .go         (go),
        .irq_en     (irq_en),
        .soft_rst   (soft_rst),
        .irq        (irq),
        .cfg_req    (cam_cfg_req)
    );

endmodule

// File: tb/tb_marker_tracker.sv
module tb_marker_tracker;

    localparam int CLK_P = 10;
    localparam int W     = 12;
    localparam int H     = 6;
    localparam logic [15:0] THR = 16'h628A; // blue 12, green 20, red 10

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cam_byte = '0;
    logic        cam_line_valid = 1'b0;
    logic        cam_frame_sync = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rd_data;
    logic        irq;
    logic        cam_cfg_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit arm_irq = 0;
    bit arm_cfg = 0;
    bit m_go = 0;
    bit m_ien = 0;
    logic [15:0] m_thr = '0;
    int exp_x = 0;
    int exp_y = 0;
    int exp_nm = 0;

    marker_tracker dut (
        .clk            (clk),
        .rst            (rst),
        .cam_byte       (cam_byte),
        .cam_line_valid (cam_line_valid),
        .cam_frame_sync (cam_frame_sync),
        .reg_wr_en      (reg_wr_en),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rd_data    (reg_rd_data),
        .irq            (irq),
        .cam_cfg_req    (cam_cfg_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-clock comparison of the pulse outputs against the model
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk("R7 irq", int'(irq), int'(arm_irq));
            chk("R8 cam_cfg_req", int'(cam_cfg_req), int'(arm_cfg));
        end
        arm_irq = 0;
        arm_cfg = 0;
    end

    function automatic bit m_match(input logic [15:0] p, input logic [15:0] t);
        return (p[4:0] >= t[4:0]) && (p[10:5] >= t[10:5]) && (p[15:11] >= t[15:11]);
    endfunction

    function automatic logic [15:0] pix_of(input int scene, input int r, input int c);
        case (scene)
            1: return (r == 3 && c == 5) ? 16'hFFFF : 16'h0000;
            2: return (r >= 2 && r <= 3 && c >= 4 && c <= 7) ? THR : 16'h0000;
            3: begin
                if (r == 1 && c == 1) return THR - 16'h0020; // green one short
                if (r == 1 && c == 2) return THR - 16'h0001; // red one short
                if (r == 1 && c == 3) return THR - 16'h0800; // blue one short
                if (r == 4 && c == 9) return THR;
                return 16'hFFFF & 16'h0000;
            end
            4: return ((r == 0 && c == 0) || (r == H-1 && c == W-1)) ? 16'hFFFF : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        if (a == 2'd0) m_thr = d;
        if (a == 2'd1) begin
            m_go  = d[0];
            m_ien = d[2];
            if (d[1]) begin
                arm_cfg = 1;
                exp_x = 0; exp_y = 0; exp_nm = 0;
            end
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        rd(2'd2, v); chk({req, " pos x"}, int'(v), exp_x);
        rd(2'd3, v); chk({req, " pos y"}, int'(v), exp_y);
        rd(2'd1, v); chk({req, " no-marker"}, int'(v[3]), exp_nm);
    endtask

    task automatic send_frame(input int scene);
        int sx = 0;
        int sy = 0;
        int n  = 0;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                logic [15:0] p;
                p = pix_of(scene, r, c);
                @(negedge clk);
                cam_line_valid = 1'b1;
                cam_byte = p[15:8];
                @(negedge clk);
                cam_byte = p[7:0];
                if (m_go && m_match(p, m_thr)) begin
                    sx += c; sy += r; n++;
                end
            end
            @(negedge clk);
            cam_line_valid = 1'b0;
            cam_byte = '0;
            @(negedge clk);
        end
        @(negedge clk);
        cam_frame_sync = 1'b1;
        if (m_go) begin
            arm_irq = m_ien;
            if (n > 0) begin
                exp_x = sx / n; exp_y = sy / n; exp_nm = 0;
            end else begin
                exp_nm = 1;
            end
        end
        @(negedge clk);
        @(negedge clk);
        cam_frame_sync = 1'b0;
        @(negedge clk);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset values
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R9 reset read", int'(v), 0);
        end

        wr(2'd0, THR);
        rd(2'd0, v); chk("R9 colour readback", int'(v), int'(THR));

        // R6: stopped core ignores a bright frame
        send_frame(1);
        check_regs("R6 idle");

        // R9/R8: control readback, reset bit reads 0
        wr(2'd1, 16'h0005);
        rd(2'd1, v); chk("R9 ctrl readback", int'(v), 5);

        send_frame(1); check_regs("R4 single pixel");
        send_frame(2); check_regs("R3 R1 equal-threshold block");
        send_frame(3); check_regs("R3 per-field decoys");
        send_frame(4); check_regs("R2 R4 corner floor");
        send_frame(0); check_regs("R5 empty frame hold");

        // R7: interrupt disabled, positions still update
        wr(2'd1, 16'h0001);
        send_frame(1); check_regs("R7 no irq frame");

        // R8: soft reset clears state
        wr(2'd1, 16'h0003);
        check_regs("R8 after soft reset");
        rd(2'd1, v); chk("R8 reset bit reads 0", int'(v[1]), 0);
        send_frame(2); check_regs("R8 frame after reset");

        repeat (3) @(negedge clk);
        report();
    end

endmodule